// File: doc/BRIEF.md
# Voice Interrupt Source Arbiter

This block collects interrupt requests from the voices of a multi-voice synthesizer and hands them to software one at a time. Each voice can raise two kinds of request. One comes from its wavetable engine when a loop or end point is reached. The other comes from its volume-ramp engine. Each kind is kept in its own pending vector. Two summary bits of a global status byte show whether either vector holds anything. The interrupt output is high while any bit of that global status byte is set. The byte is built from the two summary bits and from status bits that neighbouring blocks supply.

Software takes one request by writing the interrupt-status function code to the function-select port. The block picks one source and clears its pending bit. For one cycle it pulses the acknowledge line of that voice, so the voice logic can drop bit 7 of its own control register. It then latches a coded status byte that software reads back afterwards. All wavetable sources come before any volume-ramp source. Within a class, the lowest voice number wins.

The arbiter is a two-state machine. ST_IDLE waits for a write. The transition T_SELECT (a write of the status function code) moves it to ST_ARB. ST_ARB serves one source in its single cycle and then takes T_DONE back to ST_IDLE. If another qualifying write arrives during ST_ARB, it takes T_AGAIN and stays in ST_ARB.

Top module: `vint_arbiter`

## Requirements
- R1: Only voices 0 to 30 are scanned. A pending bit at voice 31 is never served and stays set until reset. If the wavetable vector is non-zero only because of voice 31, that arbitration returns 0xE8, and the volume-ramp vector is left untouched.
- R2: An arbitration acknowledges at most one source. It picks the lowest-numbered pending voice of the chosen class. Its acknowledge pulse is high for exactly the one cycle after the qualifying write edge.
- R3: While the wavetable vector is non-zero, no volume-ramp source is served.
- R4: Serving wavetable voice v does three things. It clears that pending bit. It pulses `wt_ack_o[v]`. From the second cycle after the write, it makes `vstat_o` equal 0x60 OR v.
- R5: Serving volume-ramp voice v does three things. It clears that pending bit. It pulses `vr_ack_o[v]`. From the second cycle after the write, it makes `vstat_o` equal 0x80 OR v.
- R6: If both vectors are zero when arbitration runs, `vstat_o` becomes 0xE8 and no acknowledge is pulsed.
- R7: Only a write of 0x8F to the function-select port starts arbitration. A write of any other value leaves the status byte and both vectors unchanged.
- R8: `gstat_o` is assembled as follows. Bit 5 is 1 exactly when the wavetable vector is non-zero. Bit 6 is 1 exactly when the volume-ramp vector is non-zero. The other bits follow `ext_stat_i`. `irq_o` is high exactly when `gstat_o` is non-zero.
- R9: A set strobe is retained even when it arrives in the cycle in which that voice, or any other voice, is acknowledged.
- R10: Reset clears both vectors, puts the machine in ST_IDLE and sets `vstat_o` to 0xE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| wt_set_i | input | 32 | Per-voice wavetable request strobes |
| vr_set_i | input | 32 | Per-voice volume-ramp request strobes |
| fsel_we_i | input | 1 | Function-select write strobe |
| fsel_wdata_i | input | 8 | Function-select write data |
| ext_stat_i | input | 8 | Global status bits from other sources (bits 5 and 6 ignored) |
| vstat_o | output | 8 | Latched voice interrupt status byte |
| wt_ack_o | output | 32 | One-cycle clear pulse for a voice's control bit 7 |
| vr_ack_o | output | 32 | One-cycle clear pulse for a voice's ramp control bit 7 |
| gstat_o | output | 8 | Global status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a set strobe that lands in the exact ARB cycle for the same voice that is being acknowledged. The same is true of a pending voice 31 that hides a waiting volume-ramp request. Directed sequences after a fresh reset build both cases on purpose. A seeded random phase then mixes sparse set patterns with frequent 0x8F writes, including back-to-back writes. This makes collisions between strobes and ARB cycles common, and a bench-side model predicts every status byte and acknowledge.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int VOICES    = 32;
    localparam int SCANNED   = 31;
    localparam int VIDX_W    = $clog2(VOICES);
    localparam logic [7:0] FSEL_IRQ_CODE = 8'h8F;
    localparam logic [7:0] CODE_WT       = 8'h60;
    localparam logic [7:0] CODE_VR       = 8'h80;
    localparam logic [7:0] CODE_NONE     = 8'hE8;
    localparam int GBIT_WT = 5;
    localparam int GBIT_VR = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ARB  = 1'b1
    } arb_state_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_WT   = 2'd1,
        CL_VR   = 2'd2
    } arb_class_e;
endpackage

// File: rtl/vint_lowest_pick.sv
module vint_lowest_pick #(
    parameter int W     = 32,
    parameter int SCAN  = 31,
    localparam int IW   = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SCAN - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_oh
        if (g < SCAN) begin : g_scan
            assign onehot[g] = found && (idx == IW'(g));
        end else begin : g_skip
            assign onehot[g] = 1'b0;
        end
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(onehot)); // R2
    end
endmodule

// File: rtl/vint_pend_vec.sv
module vint_pend_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o,
    output logic         nonempty_o
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o     = pend_q;
    assign nonempty_o = |pend_q;

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R4
    AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R9
endmodule

// File: rtl/vint_arb_fsm.sv
module vint_arb_fsm
    import vint_pkg::*;
#(
    parameter int W    = VOICES,
    parameter int SCAN = SCANNED,
    localparam int IW  = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fsel_we_i,
    input  logic [7:0]   fsel_wdata_i,
    input  logic [W-1:0] wt_pend_i,
    input  logic [W-1:0] vr_pend_i,
    output logic [W-1:0] wt_clr_o,
    output logic [W-1:0] vr_clr_o,
    output logic [7:0]   vstat_o
);
    arb_state_e state_q, state_d;
    arb_class_e cls;
    logic          sel_hit;
    logic          wt_found, vr_found;
    logic [IW-1:0] wt_idx, vr_idx;
    logic [W-1:0]  wt_oh, vr_oh;
    logic [7:0]    stat_q, stat_d;

    vint_lowest_pick #(.W(W), .SCAN(SCAN)) u_wt_pick (
        .req(wt_pend_i), .found(wt_found), .idx(wt_idx), .onehot(wt_oh));
    vint_lowest_pick #(.W(W), .SCAN(SCAN)) u_vr_pick (
        .req(vr_pend_i), .found(vr_found), .idx(vr_idx), .onehot(vr_oh));

    assign sel_hit = fsel_we_i && (fsel_wdata_i == FSEL_IRQ_CODE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_SELECT, T_AGAIN, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_hit) state_d = ST_ARB;
            ST_ARB:  state_d = sel_hit ? ST_ARB : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of ST_ARB: class choice, clear pulses, next status code
    always_comb begin
        cls      = CL_NONE;
        wt_clr_o = '0;
        vr_clr_o = '0;
        stat_d   = stat_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARB: begin
                if (wt_pend_i != '0)      cls = CL_WT;
                else if (vr_pend_i != '0) cls = CL_VR;
                stat_d = CODE_NONE;
                if (cls == CL_WT && wt_found) begin
                    wt_clr_o = wt_oh;
                    stat_d   = CODE_WT | 8'(wt_idx);
                end else if (cls == CL_VR && vr_found) begin
                    vr_clr_o = vr_oh;
                    stat_d   = CODE_VR | 8'(vr_idx);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= CODE_NONE;
        else        stat_q <= stat_d;
    end

    assign vstat_o = stat_q;

    AST_ARB_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |=> (state_q == ST_ARB)); // R7
    AST_NO_ARB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(stat_q)); // R7
    AST_WT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_clr_o != '0) |-> (wt_pend_i == '0)); // R3
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({wt_clr_o, vr_clr_o}) <= 1)); // R2
    AST_NO_V31: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != (CODE_WT | 8'd31)) && (stat_q != (CODE_VR | 8'd31))); // R1
    AST_CODE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[7:5] == 3'b011) || (stat_q[7:5] == 3'b100) || (stat_q == CODE_NONE)); // R6
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
    import vint_pkg::*;
#(
    parameter int NVOICE = VOICES,
    parameter int NSCAN  = SCANNED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NVOICE-1:0] wt_set_i,
    input  logic [NVOICE-1:0] vr_set_i,
    input  logic              fsel_we_i,
    input  logic [7:0]        fsel_wdata_i,
    input  logic [7:0]        ext_stat_i,
    output logic [7:0]        vstat_o,
    output logic [NVOICE-1:0] wt_ack_o,
    output logic [NVOICE-1:0] vr_ack_o,
    output logic [7:0]        gstat_o,
    output logic              irq_o
);
    localparam logic [7:0] OWN_MASK = (8'd1 << GBIT_WT) | (8'd1 << GBIT_VR);

    logic [NVOICE-1:0] wt_pend, vr_pend, wt_clr, vr_clr;
    logic              wt_ne, vr_ne;

    vint_pend_vec #(.W(NVOICE)) u_wt_vec (
        .clk(clk), .rst_n(rst_n), .set_i(wt_set_i), .clr_i(wt_clr),
        .pend_o(wt_pend), .nonempty_o(wt_ne));
    vint_pend_vec #(.W(NVOICE)) u_vr_vec (
        .clk(clk), .rst_n(rst_n), .set_i(vr_set_i), .clr_i(vr_clr),
        .pend_o(vr_pend), .nonempty_o(vr_ne));

    vint_arb_fsm #(.W(NVOICE), .SCAN(NSCAN)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fsel_we_i(fsel_we_i), .fsel_wdata_i(fsel_wdata_i),
        .wt_pend_i(wt_pend), .vr_pend_i(vr_pend),
        .wt_clr_o(wt_clr), .vr_clr_o(vr_clr), .vstat_o(vstat_o));

    assign wt_ack_o = wt_clr;
    assign vr_ack_o = vr_clr;

    always_comb begin
        gstat_o          = ext_stat_i & ~OWN_MASK;
        gstat_o[GBIT_WT] = wt_ne;
        gstat_o[GBIT_VR] = vr_ne;
    end

    assign irq_o = |gstat_o;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wt_ack_o | vr_ack_o) != '0) |=> ((wt_ack_o | vr_ack_o) == '0) || fsel_we_i || $past(fsel_we_i)); // R2
    AST_WT_EMPTY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_ack_o != '0) && (wt_set_i == '0) && ((wt_pend & ~wt_ack_o) == '0) |=> !gstat_o[GBIT_WT]); // R8
    AST_VR_EMPTY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_ack_o != '0) && (vr_set_i == '0) && ((vr_pend & ~vr_ack_o) == '0) |=> !gstat_o[GBIT_VR]); // R8
endmodule

// File: tb/sim_vint_arbiter.sv
module sim_vint_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wt_set = '0, vr_set = '0;
    logic        we = 1'b0;
    logic [7:0]  wd = '0, ext = '0;
    logic [7:0]  vstat, gstat;
    logic [31:0] wt_ack, vr_ack;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [31:0] m_wt, m_vr;
    logic        m_arb;
    logic [7:0]  m_stat;

    always #4 clk = ~clk;

    vint_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .wt_set_i(wt_set), .vr_set_i(vr_set),
        .fsel_we_i(we), .fsel_wdata_i(wd), .ext_stat_i(ext),
        .vstat_o(vstat), .wt_ack_o(wt_ack), .vr_ack_o(vr_ack),
        .gstat_o(gstat), .irq_o(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 31; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_gstat(input logic [7:0] e, input logic [31:0] w, input logic [31:0] r);
        return (e & 8'h9F) | {1'b0, |r, |w, 5'b0};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wt_set = '0; vr_set = '0; we = 1'b0; wd = '0; ext = '0;
        m_wt = '0; m_vr = '0; m_arb = 1'b0; m_stat = 8'hE8;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [31:0] ws, input logic [31:0] vs,
                        input logic w, input logic [7:0] d, input logic [7:0] ex);
        logic [31:0] ew, ev;
        int k;
        @(negedge clk);
        ext = ex; wt_set = ws; vr_set = vs; we = w; wd = d;
        #1;
        ew = '0; ev = '0;
        if (m_arb) begin
            if (m_wt != 0) begin
                k = lowest(m_wt);
                if (k >= 0) begin ew[k] = 1'b1; m_stat = 8'h60 | 8'(k); end
                else m_stat = 8'hE8;
            end else if (m_vr != 0) begin
                k = lowest(m_vr);
                if (k >= 0) begin ev[k] = 1'b1; m_stat = 8'h80 | 8'(k); end
                else m_stat = 8'hE8;
            end else m_stat = 8'hE8;
        end
        chk("R2 wt ack", wt_ack, ew);
        chk("R2 vr ack", vr_ack, ev);
        chk("R8 gstat", {24'b0, gstat}, {24'b0, exp_gstat(ex, m_wt, m_vr)});
        chk("R8 irq", {31'b0, irq}, {31'b0, exp_gstat(ex, m_wt, m_vr) != 0});
        m_wt = (m_wt & ~ew) | ws;
        m_vr = (m_vr & ~ev) | vs;
        m_arb = w && (d == 8'h8F);
        @(posedge clk);
        #2;
        if (m_stat[7:5] == 3'b011)      chk("R4 status", {24'b0, vstat}, {24'b0, m_stat});
        else if (m_stat[7:5] == 3'b100) chk("R5 status", {24'b0, vstat}, {24'b0, m_stat});
        else                            chk("R6 status", {24'b0, vstat}, {24'b0, m_stat});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        #1;
        chk("R10 reset status", {24'b0, vstat}, 32'hE8);
        chk("R10 reset gstat", {24'b0, gstat}, 32'h0);
        chk("R10 reset irq", {31'b0, irq}, 32'h0);

        // R6: empty arbitration
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        idle(2);
        chk("R6 empty", {24'b0, vstat}, 32'hE8);

        // R3 / R4 / R5: wt class first, then ramp
        step(32'h0000_0880, 32'h0000_0006, 1'b0, 8'h00, 8'h00);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        #0 chk("R3 no vr ack in arb", vr_ack, 32'h0);
        chk("R4 ack voice7", wt_ack, 32'h0000_0080);
        idle(1);
        chk("R4 code voice7", {24'b0, vstat}, 32'h67);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        idle(1);
        chk("R4 code voice11", {24'b0, vstat}, 32'h6B);
        chk("R8 wt empty bit5", {31'b0, gstat[5]}, 32'h0);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        idle(1);
        chk("R5 code voice1", {24'b0, vstat}, 32'h81);

        // R7: other function codes do nothing
        step('0, '0, 1'b1, 8'h8E, 8'h00);
        idle(2);
        chk("R7 status held", {24'b0, vstat}, 32'h81);
        chk("R7 vr still pending", {31'b0, gstat[6]}, 32'h1);

        // R9: set of the same voice during its acknowledge cycle
        do_reset();
        step(32'h0000_0010, '0, 1'b0, 8'h00, 8'h00);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        step(32'h0000_0210, '0, 1'b0, 8'h00, 8'h00);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        idle(1);
        chk("R9 retained voice4", {24'b0, vstat}, 32'h64);

        // R1: voice 31 hides the ramp class
        do_reset();
        step(32'h8000_0000, 32'h0000_0004, 1'b0, 8'h00, 8'h00);
        step('0, '0, 1'b1, 8'h8F, 8'h00);
        chk("R1 no ack", wt_ack | vr_ack, 32'h0);
        idle(1);
        chk("R1 status none", {24'b0, vstat}, 32'hE8);
        chk("R1 both still pending", {30'b0, gstat[6:5]}, 32'h3);

        // random mix, including back-to-back selects
        do_reset();
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ws, vs;
            logic        w;
            logic [7:0]  d;
            ws = $urandom & $urandom & $urandom & $urandom;
            vs = $urandom & $urandom & $urandom & $urandom;
            if ($urandom_range(3) != 0) ws = '0;
            if ($urandom_range(3) != 0) vs = '0;
            w = ($urandom_range(2) == 0);
            d = ($urandom_range(4) == 0) ? 8'($urandom) : 8'h8F;
            step(ws, vs, w, d, ($urandom_range(5) == 0) ? 8'($urandom) : 8'h00);
        end
        idle(2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule